// File: doc/BRIEF.md
# Single-Cycle Data Bank Redirector

This block sits in a cartridge-style ROM mapper and lets a program execute from one ROM bank while a single operand byte is read from another. It watches every bus cycle, recognises a small set of load-type opcodes as they are fetched, follows the instruction through its operand cycles, and for the one cycle that reads the data byte it steers the ROM window to a separately held data bank. On the next cycle the window is back on the code bank.

Both banks live in registers that software loads by writing to two fixed hot-spot addresses in cartridge space; the low bits of the written byte give the bank number. The CPU's opcode-fetch marker (the line that is high while an opcode byte is read) tells the block where instructions start. For indexed forms the block finds a page crossing by comparing the low address byte of the first read cycle with the captured low operand byte, so the override still covers only the read that returns real data.

Top module: `dbr_redirect`

## Requirements
- R1: After reset the code and data banks are both 0, the decoder is idle and `bank_sel` reads 0.
- R2: A write cycle (`cpu_rw`=0) to address 0x1FF0 loads the code bank from `cpu_data[2:0]`; it shows on `bank_sel` from the following cycle on every cycle that is not overridden.
- R3: A write cycle to address 0x1FF1 loads the data bank from `cpu_data[2:0]` and leaves the code bank unchanged.
- R4: Only opcodes 0xAD, 0x2D, 0x2C (absolute) and 0xBD, 0xB9, 0x3D, 0x39 (indexed) start an override; every other opcode leaves `bank_sel` on the code bank on all following cycles.
- R5: For an absolute trigger fetched in cycle 0, `bank_sel` shows the data bank in cycle 3 only; cycles 0, 1 and 2 show the code bank.
- R6: For an indexed trigger whose cycle-3 address low byte is not below the low operand byte read in cycle 1, the override falls on cycle 3 only.
- R7: For an indexed trigger whose cycle-3 address low byte is below the low operand byte (page crossed), cycle 3 shows the code bank and cycle 4 shows the data bank.
- R8: Opcode-fetch cycles and write cycles always show the code bank; an opcode fetch arriving before the data read cancels the pending override.
- R9: An override never lasts more than one cycle; the cycle after it shows the code bank.
- R10: An override does not alter the code bank register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus cycle clock; each rising edge ends one bus cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_addr | input | 13 | Cartridge address of the current bus cycle |
| cpu_data | input | 8 | Data bus byte: ROM byte on reads, CPU byte on writes |
| cpu_rw | input | 1 | 1 = read cycle, 0 = write cycle |
| op_fetch | input | 1 | High while the current cycle fetches an opcode |
| bank_sel | output | 3 | Effective ROM bank for the current cycle |

## Verification
On every cycle the assertions check that an override is never followed by another override, that the code bank holds still across an override, that the data read state is only reached through the operand states, that a page-cross read only follows a crossed first read, and that a data-bank write lands the written value. Which cycle of an instruction gets redirected, for every one of the 256 opcodes with crossing and non-crossing operand and index pairs, only the bench's sweep can show, as can the effect of interrupting opcode fetches, write cycles in the read slot, and bank-register loads followed by reset.

// File: rtl/dbr_pkg.sv
package dbr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LO   = 3'd1,
    ST_HI   = 3'd2,
    ST_RD   = 3'd3,
    ST_FIX  = 3'd4
  } seq_state_e;

  typedef enum logic [1:0] {
    CLS_NONE = 2'd0,
    CLS_ABS  = 2'd1,
    CLS_IDX  = 2'd2
  } op_class_e;

  localparam logic [7:0] OP_LOAD_ABS  = 8'hAD;
  localparam logic [7:0] OP_LOAD_ABX  = 8'hBD;
  localparam logic [7:0] OP_LOAD_ABY  = 8'hB9;
  localparam logic [7:0] OP_MASK_ABS  = 8'h2D;
  localparam logic [7:0] OP_MASK_ABX  = 8'h3D;
  localparam logic [7:0] OP_MASK_ABY  = 8'h39;
  localparam logic [7:0] OP_TEST_ABS  = 8'h2C;

endpackage

// File: rtl/dbr_op_decode.sv
module dbr_op_decode
  import dbr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] opcode,
  output op_class_e         cls
);

  always_comb begin
    unique case (opcode[7:0])
      OP_LOAD_ABS, OP_MASK_ABS, OP_TEST_ABS: cls = CLS_ABS;
      OP_LOAD_ABX, OP_LOAD_ABY,
      OP_MASK_ABX, OP_MASK_ABY:              cls = CLS_IDX;
      default:                               cls = CLS_NONE;
    endcase
  end

endmodule

// File: rtl/dbr_seq.sv
module dbr_seq
  import dbr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_fetch,
  input  logic              rd,
  input  logic [DATA_W-1:0] bus_data,
  input  logic [7:0]        addr_lo,
  output logic              ovr
);

  seq_state_e state_q, state_d;
  logic       idx_q, idx_d;
  logic [7:0] oplo_q, oplo_d;
  logic       ovr_raw;
  logic       crossed;
  logic       fetch_en;
  op_class_e  cls;

  dbr_op_decode #(.DATA_W(DATA_W)) u_dec (
    .opcode (bus_data),
    .cls    (cls)
  );

  assign crossed  = (addr_lo < oplo_q);
  assign fetch_en = op_fetch & rd;

  // next-state logic
  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    oplo_d  = oplo_q;
    ovr_raw = 1'b0;
    unique case (state_q)
      ST_LO: begin
        oplo_d  = bus_data[7:0];
        state_d = ST_HI;
      end
      ST_HI: state_d = ST_RD;
      ST_RD: begin
        if (!idx_q || !crossed) begin
          ovr_raw = 1'b1;
          state_d = ST_IDLE;
        end else begin
          state_d = ST_FIX;
        end
      end
      ST_FIX: begin
        ovr_raw = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
    if (op_fetch) begin
      ovr_raw = 1'b0;
      state_d = (fetch_en && cls != CLS_NONE) ? ST_LO : ST_IDLE;
      idx_d   = (cls == CLS_IDX);
    end
  end

  assign ovr = ovr_raw & rd;

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= 1'b0;
      oplo_q  <= 8'h00;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      oplo_q  <= oplo_d;
    end
  end

  // R5: the read state is only entered from the high-operand state
  p_read_after_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RD) |-> ($past(state_q) == ST_HI));

  // R7: the page-cross state only follows a read state of an indexed form
  p_fix_after_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FIX) |-> ($past(state_q) == ST_RD && idx_q));

  // R8: no override while an opcode is being fetched
  p_fetch_no_ovr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    op_fetch |-> !ovr);

endmodule

// File: rtl/dbr_bank_regs.sv
module dbr_bank_regs #(
  parameter int              ADDR_W   = 13,
  parameter int              DATA_W   = 8,
  parameter int              BANK_W   = 3,
  parameter logic [ADDR_W-1:0] HOT_CODE = 13'h1FF0,
  parameter logic [ADDR_W-1:0] HOT_DATA = 13'h1FF1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic [DATA_W-1:0] wr_data,
  output logic [BANK_W-1:0] code_bank,
  output logic [BANK_W-1:0] data_bank
);

  logic              code_we, data_we;
  logic [BANK_W-1:0] code_d, data_d;

  assign code_we = !rd && (addr == HOT_CODE);
  assign data_we = !rd && (addr == HOT_DATA);

  always_comb begin
    code_d = code_bank;
    data_d = data_bank;
    if (code_we) code_d = wr_data[BANK_W-1:0];
    if (data_we) data_d = wr_data[BANK_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_bank <= '0;
      data_bank <= '0;
    end else begin
      code_bank <= code_d;
      data_bank <= data_d;
    end
  end

  // R3: a data hot-spot write lands the written value
  p_data_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    data_we |=> (data_bank == $past(wr_data[BANK_W-1:0])));

  // R3: a data hot-spot write does not move the code bank
  p_data_keeps_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && !code_we) |=> $stable(code_bank));

endmodule

// File: rtl/dbr_redirect.sv
module dbr_redirect #(
  parameter int                ADDR_W   = 13,
  parameter int                DATA_W   = 8,
  parameter int                BANK_W   = 3,
  parameter logic [ADDR_W-1:0] HOT_CODE = 13'h1FF0,
  parameter logic [ADDR_W-1:0] HOT_DATA = 13'h1FF1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_data,
  input  logic              cpu_rw,
  input  logic              op_fetch,
  output logic [BANK_W-1:0] bank_sel
);

  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;
  logic                   ovr;
  logic [BANK_W-1:0]      code_bank, data_bank;

  // reset: asserted at once, released after SYNC_STAGES edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  dbr_bank_regs #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .BANK_W   (BANK_W),
    .HOT_CODE (HOT_CODE),
    .HOT_DATA (HOT_DATA)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .addr      (cpu_addr),
    .rd        (cpu_rw),
    .wr_data   (cpu_data),
    .code_bank (code_bank),
    .data_bank (data_bank)
  );

  dbr_seq #(.DATA_W(DATA_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .op_fetch (op_fetch),
    .rd       (cpu_rw),
    .bus_data (cpu_data),
    .addr_lo  (cpu_addr[7:0]),
    .ovr      (ovr)
  );

  assign bank_sel = ovr ? data_bank : code_bank;

  // R9: an override is never followed by another one
  p_single_cycle_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    ovr |=> !ovr);

  // R10: the code bank register holds through an override
  p_code_hold_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    ovr |=> $stable(code_bank));

endmodule

// File: tb/dbr_redirect_test.sv
`timescale 1ns/100ps
module dbr_redirect_test;

  localparam logic [12:0] HOT_CODE = 13'h1FF0;
  localparam logic [12:0] HOT_DATA = 13'h1FF1;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [12:0] cpu_addr;
  logic [7:0]  cpu_data;
  logic        cpu_rw;
  logic        op_fetch;
  logic [2:0]  bank_sel;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;
  logic [2:0] cur_code, cur_data;

  always #2.5 clk = ~clk;

  dbr_redirect uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_addr (cpu_addr),
    .cpu_data (cpu_data),
    .cpu_rw   (cpu_rw),
    .op_fetch (op_fetch),
    .bank_sel (bank_sel)
  );

  // bench's own opcode classification: 0 none, 1 absolute, 2 indexed (R4)
  function automatic int op_kind(input logic [7:0] op);
    case (op)
      8'hAD, 8'h2D, 8'h2C:        return 1;
      8'hBD, 8'hB9, 8'h3D, 8'h39: return 2;
      default:                    return 0;
    endcase
  endfunction

  // one bus cycle: drive after falling edge, sample before rising edge
  task automatic step(input logic [12:0] a, input logic [7:0] d,
                      input logic rw, input logic f,
                      input logic [2:0] exp, input string req);
    @(negedge clk);
    cpu_addr = a; cpu_data = d; cpu_rw = rw; op_fetch = f;
    #1;
    vectors++;
    if (bank_sel !== exp) begin
      fails++;
      $display("FAIL %s addr=%h data=%h: bank_sel=%0d expected=%0d",
               req, a, d, bank_sel, exp);
    end
  endtask

  task automatic set_code(input logic [2:0] b);
    step(HOT_CODE, {5'h0, b}, 1'b0, 1'b0, cur_code, "R2 write cycle");
    cur_code = b;
  endtask

  task automatic set_data(input logic [2:0] b);
    step(HOT_DATA, {5'h0, b}, 1'b0, 1'b0, cur_code, "R3 write cycle");
    cur_data = b;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cpu_addr = 13'h1000; cpu_data = 8'hEA;
    cpu_rw = 1'b1; op_fetch = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    cur_code = 3'd0; cur_data = 3'd0;
  endtask

  // full instruction from opcode fetch to the cycle after its data read
  task automatic run_instr(input logic [7:0] op, input logic [7:0] lo,
                           input logic [7:0] x);
    int kind = op_kind(op);
    int sum  = int'(lo) + int'(x);
    logic [7:0] a3 = (kind == 2) ? sum[7:0] : lo;
    bit crossed = (kind == 2) && (sum > 255);
    step(13'h1100, op,    1'b1, 1'b1, cur_code, "R8 opcode fetch");
    step(13'h1101, lo,    1'b1, 1'b0, cur_code, "R5 operand low");
    step(13'h1102, 8'h1A, 1'b1, 1'b0, cur_code, "R5 operand high");
    if (kind == 0)
      step({5'h1A, a3}, 8'h55, 1'b1, 1'b0, cur_code, "R4 non-trigger read");
    else if (kind == 1)
      step({5'h1A, a3}, 8'h55, 1'b1, 1'b0, cur_data, "R5 absolute data read");
    else if (!crossed)
      step({5'h1A, a3}, 8'h55, 1'b1, 1'b0, cur_data, "R6 indexed data read");
    else begin
      step({5'h1A, a3}, 8'h55, 1'b1, 1'b0, cur_code, "R7 dummy read");
      step({5'h1B, a3}, 8'h55, 1'b1, 1'b0, cur_data, "R7 page-cross read");
    end
    if (kind == 0)
      step({5'h1A, a3}, 8'h66, 1'b1, 1'b0, cur_code, "R4 non-trigger extra read");
    // next instruction start is back on code bank
    step(13'h1104, 8'hEA, 1'b1, 1'b1, cur_code, "R9 cycle after override");
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] los [4] = '{8'h00, 8'h80, 8'hF0, 8'hFF};
    logic [7:0] xs  [4] = '{8'h00, 8'h7F, 8'h10, 8'h01};
    do_reset();

    // R1: reset state
    step(13'h1000, 8'hEA, 1'b1, 1'b0, 3'd0, "R1 reset bank");
    run_instr(8'hAD, 8'h10, 8'h00); // R1: data bank reads 0 too

    // R2, R3: hot-spot loads
    set_code(3'd5);
    step(13'h1000, 8'hEA, 1'b1, 1'b0, 3'd5, "R2 code bank loaded");
    set_data(3'd2);
    step(13'h1000, 8'hEA, 1'b1, 1'b0, 3'd5, "R3 code bank unchanged");
    run_instr(8'hAD, 8'h20, 8'h00);

    // R4-R7 sweep over all opcodes and several operand/index pairs
    for (int op = 0; op < 256; op++) begin
      logic [2:0] c = op[2:0];
      logic [2:0] d = 3'((int'(c) + 1 + ((op >> 3) % 7)) % 8);
      set_code(c);
      set_data(d);
      for (int k = 0; k < 4; k++) run_instr(op[7:0], los[k], xs[k]);
    end

    // R10: code bank intact after overrides
    set_code(3'd6);
    set_data(3'd1);
    run_instr(8'hBD, 8'hF0, 8'h20);
    step(13'h1000, 8'hEA, 1'b1, 1'b0, 3'd6, "R10 code bank after override");

    // R8: write cycle in the data slot stays on code bank
    step(13'h1100, 8'hAD, 1'b1, 1'b1, cur_code, "R8 fetch");
    step(13'h1101, 8'h40, 1'b1, 1'b0, cur_code, "R8 lo");
    step(13'h1102, 8'h1A, 1'b1, 1'b0, cur_code, "R8 hi");
    step(13'h1A40, 8'h77, 1'b0, 1'b0, cur_code, "R8 write in data slot");
    step(13'h1103, 8'hEA, 1'b1, 1'b1, cur_code, "R8 next fetch");

    // R8: opcode fetch before the data read cancels the override
    step(13'h1100, 8'h2D, 1'b1, 1'b1, cur_code, "R8 fetch");
    step(13'h1101, 8'h40, 1'b1, 1'b0, cur_code, "R8 lo");
    step(13'h1200, 8'hEA, 1'b1, 1'b1, cur_code, "R8 interrupting fetch");
    step(13'h1201, 8'h00, 1'b1, 1'b0, cur_code, "R8 cancelled read");
    step(13'h1202, 8'h00, 1'b1, 1'b0, cur_code, "R8 cancelled read");

    // R1: reset after loading both banks
    set_code(3'd7);
    set_data(3'd3);
    do_reset();
    step(13'h1000, 8'hEA, 1'b1, 1'b0, 3'd0, "R1 code bank after reset");
    run_instr(8'hB9, 8'h01, 8'h02);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule